// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is the execution stage of a packed integer datapath. It takes two 64-bit operands and applies one operation to every lane at the same time. An element-size select splits each operand into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. The operation set covers lane-wise addition and subtraction, compares, whole-register logic, whole-register logical shifts, and interleaving of lanes taken from both operands.

A compare gives a mask rather than a flag. Every lane where the relation holds comes back as all ones, and every other lane comes back as all zeros. A later AND, AND-NOT and OR sequence can then pick values lane by lane without a branch. Saturating arithmetic clamps each lane to the edge of its range and gives no indication that it did so. The result is captured in a register one clock after a valid request.

Top module: `simd_alu`

## Requirements
- R1: When `in_valid` is high at a rising edge, `result` and `out_valid` (high) show that request after that edge. When `in_valid` is low, `out_valid` goes low after the edge and `result` keeps its value. Synchronous reset clears both outputs to zero.
- R2: `elem_size` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane 0 occupies the least significant bits. Opcode 0x0 adds and opcode 0x3 subtracts (a minus b) in every lane, modulo the lane width.
- R3: Opcodes 0x1 (add) and 0x4 (subtract) on 8-bit or 16-bit lanes treat lanes as signed. A result above the signed maximum becomes that maximum, and a result below the signed minimum becomes that minimum.
- R4: Opcodes 0x2 (add) and 0x5 (subtract) on 8-bit or 16-bit lanes treat lanes as unsigned. An add that overflows gives all ones, and a subtract that goes below zero gives zero.
- R5: The four saturating opcodes (0x1, 0x2, 0x4, 0x5) on 32-bit or 64-bit lanes wrap modulo the lane width, in the same way as opcodes 0x0 and 0x3.
- R6: Opcode 0x6 sets each lane to all ones when the a and b lanes are equal, and to all zeros otherwise.
- R7: Opcode 0x7 sets each lane to all ones when the a lane is greater than the b lane as signed values, and to all zeros otherwise.
- R8: Opcodes 0x8 (a AND b), 0x9 ((NOT a) AND b), 0xA (a OR b) and 0xB (a XOR b) act on all 64 bits. `elem_size` has no effect on them.
- R9: Opcode 0xC shifts a left and opcode 0xD shifts a right, both logically, over all 64 bits. The shift count is the whole of b taken as unsigned, and a count of 64 or more gives zero. `elem_size` has no effect on them.
- R10: Opcode 0xE interleaves the lower halves of the operands: result lane 2i is a lane i and result lane 2i+1 is b lane i. With 64-bit lanes the result is a.
- R11: Opcode 0xF interleaves the upper halves of the operands: result lane 2i is a lane i+N/2 and result lane 2i+1 is b lane i+N/2, for N lanes. With 64-bit lanes the result is b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| opcode | input | 4 | Operation code |
| elem_size | input | 2 | Lane width select |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand; also the shift count |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Registered result |

## Verification
The hardest cases to reach are the saturation boundaries. Each lane only clamps when its own operands sit at the exact edge of the signed or unsigned range, so random 64-bit operands almost never make a single lane cross by exactly one. The stimulus therefore builds operands from a small pool of lane values: zero, one, all ones, the signed maximum and the signed minimum. These are repeated into every lane and mixed with random lanes. Each boundary is also driven directly at every lane width, including the wide widths where the same opcodes must wrap instead of clamping.

// File: rtl/simd_alu_pkg.sv
// Shared types for the packed integer ALU: operation codes and lane sizes.
// Assumes a 4-bit opcode and a 2-bit lane size field at the block edge.
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'h0,
        OP_ADDSS  = 4'h1,
        OP_ADDUS  = 4'h2,
        OP_SUB    = 4'h3,
        OP_SUBSS  = 4'h4,
        OP_SUBUS  = 4'h5,
        OP_CMPEQ  = 4'h6,
        OP_CMPGT  = 4'h7,
        OP_AND    = 4'h8,
        OP_ANDN   = 4'h9,
        OP_OR     = 4'hA,
        OP_XOR    = 4'hB,
        OP_SLL    = 4'hC,
        OP_SRL    = 4'hD,
        OP_UNPKLO = 4'hE,
        OP_UNPKHI = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } alu_size_e;

    localparam int NUM_SIZES = 4;

endpackage

// File: rtl/simd_lane_unit.sv
// One lane of arithmetic and compare. Computes wrap, signed-saturating and
// unsigned-saturating add/sub, equality mask and signed greater-than mask.
// Assumes SAT_EN is 0 for wide lanes, where the saturating codes wrap.
module simd_lane_unit
    import simd_alu_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter bit SAT_EN = 1'b1
) (
    input  alu_op_e           op,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] res
);
    localparam int MSB = LANE_W - 1;
    localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};

    logic [LANE_W:0] sum;
    logic [LANE_W:0] dif;
    logic            sovf_add;
    logic            sovf_sub;

    // Widened sum and difference; the top bit is carry or borrow.
    always_comb begin
        sum      = {1'b0, a} + {1'b0, b};
        dif      = {1'b0, a} - {1'b0, b};
        sovf_add = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
        sovf_sub = (a[MSB] != b[MSB]) && (dif[MSB] != a[MSB]);
    end

    // Select the lane outcome for the requested operation.
    always_comb begin
        case (op)
            OP_ADD:   res = sum[LANE_W-1:0];
            OP_SUB:   res = dif[LANE_W-1:0];
            OP_ADDSS: res = (SAT_EN && sovf_add) ? (a[MSB] ? SMIN : SMAX) : sum[LANE_W-1:0];
            OP_SUBSS: res = (SAT_EN && sovf_sub) ? (a[MSB] ? SMIN : SMAX) : dif[LANE_W-1:0];
            OP_ADDUS: res = (SAT_EN && sum[LANE_W]) ? '1 : sum[LANE_W-1:0];
            OP_SUBUS: res = (SAT_EN && dif[LANE_W]) ? '0 : dif[LANE_W-1:0];
            OP_CMPEQ: res = (a == b) ? '1 : '0;
            OP_CMPGT: res = ($signed(a) > $signed(b)) ? '1 : '0;
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/simd_logic_shift.sv
// Whole-register bitwise logic and logical shifts. The shift count is the
// full second operand; any count at or beyond the width yields zero.
// Assumes DATA_W is a power of two.
module simd_logic_shift
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [CNT_W-1:0] cnt;
    logic             flush;

    // Split the count into an in-range amount and an out-of-range flag.
    always_comb begin
        cnt   = b[CNT_W-1:0];
        flush = |b[DATA_W-1:CNT_W];
    end

    // Operation select across the full register.
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_ANDN: res = ~a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_SLL:  res = flush ? '0 : (a << cnt);
            OP_SRL:  res = flush ? '0 : (a >> cnt);
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/simd_interleave.sv
// Interleaves lanes of two operands for one lane width. The low output takes
// the lower halves, the high output the upper halves; a lane from a always
// lands below the matching lane from b. A single-lane width passes a and b.
module simd_interleave #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] lo,
    output logic [DATA_W-1:0] hi
);
    localparam int NL   = DATA_W / LANE_W;
    localparam int HALF = NL / 2;

    generate
        if (NL == 1) begin : g_single
            // One lane: nothing to interleave.
            assign lo = a;
            assign hi = b;
        end else begin : g_multi
            for (genvar i = 0; i < HALF; i++) begin : g_pair
                // Pair lane i (or i+HALF) of a with the same lane of b.
                assign lo[(2*i)*LANE_W   +: LANE_W] = a[i*LANE_W        +: LANE_W];
                assign lo[(2*i+1)*LANE_W +: LANE_W] = b[i*LANE_W        +: LANE_W];
                assign hi[(2*i)*LANE_W   +: LANE_W] = a[(i+HALF)*LANE_W +: LANE_W];
                assign hi[(2*i+1)*LANE_W +: LANE_W] = b[(i+HALF)*LANE_W +: LANE_W];
            end
        end
    endgenerate

endmodule

// File: rtl/simd_alu.sv
// Packed integer ALU top. Builds lane arrays for every lane width, selects
// by opcode and width, and registers the result with a valid strobe.
// Assumes DATA_W is a power of two and a multiple of 8 lanes of 8 bits.
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        opcode,
    input  logic [1:0]        elem_size,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int MIN_LANE = DATA_W / 8;
    localparam int CNT_W    = $clog2(DATA_W);

    alu_op_e           op_e;
    logic [DATA_W-1:0] lane_res [NUM_SIZES];
    logic [DATA_W-1:0] unp_lo   [NUM_SIZES];
    logic [DATA_W-1:0] unp_hi   [NUM_SIZES];
    logic [DATA_W-1:0] ls_res;
    logic [DATA_W-1:0] nxt;

    assign op_e = alu_op_e'(opcode);

    generate
        for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
            localparam int LW = MIN_LANE << s;
            localparam int NL = DATA_W / LW;
            logic [DATA_W-1:0] vec;

            for (genvar l = 0; l < NL; l++) begin : g_lane
                simd_lane_unit #(
                    .LANE_W (LW),
                    .SAT_EN (LW <= 16)
                ) u_lane (
                    .op  (op_e),
                    .a   (src_a[l*LW +: LW]),
                    .b   (src_b[l*LW +: LW]),
                    .res (vec[l*LW +: LW])
                );
            end
            assign lane_res[s] = vec;

            simd_interleave #(
                .DATA_W (DATA_W),
                .LANE_W (LW)
            ) u_ilv (
                .a  (src_a),
                .b  (src_b),
                .lo (unp_lo[s]),
                .hi (unp_hi[s])
            );
        end
    endgenerate

    simd_logic_shift #(
        .DATA_W (DATA_W)
    ) u_logic (
        .op  (op_e),
        .a   (src_a),
        .b   (src_b),
        .res (ls_res)
    );

    // Route the unit that owns the requested opcode to the register input.
    always_comb begin
        case (op_e)
            OP_AND, OP_ANDN, OP_OR, OP_XOR, OP_SLL, OP_SRL: nxt = ls_res;
            OP_UNPKLO: nxt = unp_lo[elem_size];
            OP_UNPKHI: nxt = unp_hi[elem_size];
            default:   nxt = lane_res[elem_size];
        endcase
    end

    // Output register: capture on a valid request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nxt;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result))); // R1
    AST_UNSIGNED_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_ADDUS && elem_size <= 2'd1 && src_b == '1) |=> (result == '1)); // R4
    AST_EQ_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_CMPEQ && src_a == src_b) |=> (result == '1)); // R6
    AST_GT_IRREFLEXIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_CMPGT && src_a == src_b) |=> (result == '0)); // R7
    AST_SHIFT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_e == OP_SLL || op_e == OP_SRL) && (|src_b[DATA_W-1:CNT_W])) |=> (result == '0)); // R9
    AST_UNPK_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_UNPKHI && elem_size == 2'd3) |=> (result == $past(src_b))); // R11

endmodule

// File: tb/simd_alu_tb.sv
module simd_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic [1:0]  elem_size = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_res = '0;

    always #5 clk = ~clk;

    simd_alu u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .elem_size (elem_size),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [63:0] lane_mask(int lw);
        return (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
    endfunction

    // Behavioural reference built from the requirement text.
    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                          logic [3:0] op, logic [1:0] sz);
        int lw = 8 << sz;
        int nl = 64 / lw;
        logic [63:0] m = lane_mask(lw);
        logic [63:0] hb = 64'd1 << (lw - 1);
        logic [63:0] r = '0;
        case (op)
            4'h8: r = a & b;
            4'h9: r = ~a & b;
            4'hA: r = a | b;
            4'hB: r = a ^ b;
            4'hC: r = (b >= 64) ? 64'd0 : (a << b[5:0]);
            4'hD: r = (b >= 64) ? 64'd0 : (a >> b[5:0]);
            4'hE, 4'hF: begin
                if (nl == 1) r = (op == 4'hE) ? a : b;
                else for (int i = 0; i < nl / 2; i++) begin
                    int src = i + ((op == 4'hF) ? nl / 2 : 0);
                    r |= ((a >> (src * lw)) & m) << (2 * i * lw);
                    r |= ((b >> (src * lw)) & m) << ((2 * i + 1) * lw);
                end
            end
            default: begin
                for (int i = 0; i < nl; i++) begin
                    logic [63:0] x = (a >> (i * lw)) & m;
                    logic [63:0] y = (b >> (i * lw)) & m;
                    logic [64:0] t;
                    logic [63:0] z;
                    longint half = longint'(m >> 1) + 1;
                    longint ix, iy, v;
                    case (op)
                        4'h0: z = x + y;
                        4'h3: z = x - y;
                        4'h2: if (lw > 16) z = x + y;
                              else begin t = x + y; z = (t > m) ? m : t[63:0]; end
                        4'h5: z = (lw > 16) ? x - y : ((x < y) ? 64'd0 : x - y);
                        4'h1, 4'h4: begin
                            if (lw > 16) z = (op == 4'h1) ? x + y : x - y;
                            else begin
                                ix = (x >= 64'(half)) ? longint'(x) - 2 * half : longint'(x);
                                iy = (y >= 64'(half)) ? longint'(y) - 2 * half : longint'(y);
                                v = (op == 4'h1) ? ix + iy : ix - iy;
                                if (v > half - 1) v = half - 1;
                                if (v < -half) v = -half;
                                z = 64'(v);
                            end
                        end
                        4'h6: z = (x == y) ? m : 64'd0;
                        default: z = ((x ^ hb) > (y ^ hb)) ? m : 64'd0;
                    endcase
                    r |= (z & m) << (i * lw);
                end
            end
        endcase
        return r;
    endfunction

    function automatic string tag_of(logic [3:0] op, logic [1:0] sz);
        case (op)
            4'h0, 4'h3: return "R2";
            4'h1, 4'h4: return (sz <= 2'd1) ? "R3" : "R5";
            4'h2, 4'h5: return (sz <= 2'd1) ? "R4" : "R5";
            4'h6: return "R6";
            4'h7: return "R7";
            4'h8, 4'h9, 4'hA, 4'hB: return "R8";
            4'hC, 4'hD: return "R9";
            4'hE: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one cycle at a falling edge, then compare at the next one.
    task automatic xact(logic v, logic [3:0] op, logic [1:0] sz,
                        logic [63:0] a, logic [63:0] b);
        string tag = "R1";
        in_valid = v; opcode = op; elem_size = sz; src_a = a; src_b = b;
        if (v) begin
            exp_res = model(a, b, op, sz);
            tag = tag_of(op, sz);
        end
        @(negedge clk);
        check(tag, result, exp_res);
        check("R1", {63'd0, out_valid}, {63'd0, v});
    endtask

    function automatic logic [63:0] splat(logic [63:0] pat, logic [1:0] sz);
        int lw = 8 << sz;
        logic [63:0] r = '0;
        for (int i = 0; i < 64 / lw; i++) r |= (pat & lane_mask(lw)) << (i * lw);
        return r;
    endfunction

    function automatic logic [63:0] edge_val(int k, logic [1:0] sz);
        int lw = 8 << sz;
        logic [63:0] m = lane_mask(lw);
        case (k)
            0: return 64'd0;
            1: return splat(64'd1, sz);
            2: return splat(m, sz);
            3: return splat(m >> 1, sz);
            4: return splat((m >> 1) + 64'd1, sz);
            default: return {$urandom, $urandom};
        endcase
    endfunction

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1: watchdog expired, got hung run expected completion");
        summary();
    end

    initial begin
        logic [63:0] mask_q, sel;
        repeat (3) @(negedge clk);
        check("R1", result, 64'd0);
        check("R1", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;

        // Saturation edges at every width (R3, R4, R5).
        for (int sz = 0; sz < 4; sz++)
            for (int op = 0; op < 6; op++)
                for (int i = 0; i < 5; i++)
                    for (int j = 0; j < 5; j++)
                        xact(1'b1, op[3:0], sz[1:0], edge_val(i, sz[1:0]), edge_val(j, sz[1:0]));

        // Compares on equal, mixed and signed-edge lanes (R6, R7).
        for (int sz = 0; sz < 4; sz++) begin
            xact(1'b1, 4'h6, sz[1:0], 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF);
            xact(1'b1, 4'h6, sz[1:0], 64'h0123_4567_89AB_CDEF, 64'h0123_0067_89AB_CD00);
            xact(1'b1, 4'h7, sz[1:0], edge_val(3, sz[1:0]), edge_val(4, sz[1:0]));
            xact(1'b1, 4'h7, sz[1:0], edge_val(4, sz[1:0]), edge_val(3, sz[1:0]));
            xact(1'b1, 4'h7, sz[1:0], 64'h8000_0001_7FFF_0000, 64'h0000_0001_8000_FFFF);
        end

        // Shift counts at and past the width, size ignored (R9).
        for (int sz = 0; sz < 4; sz++) begin
            xact(1'b1, 4'hC, sz[1:0], 64'hF00D_CAFE_1234_5678, 64'd0);
            xact(1'b1, 4'hC, sz[1:0], 64'hF00D_CAFE_1234_5678, 64'd63);
            xact(1'b1, 4'hD, sz[1:0], 64'hF00D_CAFE_1234_5678, 64'd64);
            xact(1'b1, 4'hD, sz[1:0], 64'hF00D_CAFE_1234_5678, 64'h1_0000_0003);
            xact(1'b1, 4'hD, sz[1:0], 64'hF00D_CAFE_1234_5678, 64'd13);
        end

        // Interleave at every width, including replication (R10, R11).
        for (int sz = 0; sz < 4; sz++) begin
            xact(1'b1, 4'hE, sz[1:0], 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110);
            xact(1'b1, 4'hF, sz[1:0], 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110);
            xact(1'b1, 4'hE, sz[1:0], 64'h0000_0000_0000_00AB, 64'h0000_0000_0000_00AB);
        end

        // Branch-free select from a compare mask (R7, R8).
        xact(1'b1, 4'h7, 2'd1, 64'h0005_FFFF_7000_0001, 64'h0004_0000_7001_0001);
        mask_q = result;
        xact(1'b1, 4'h8, 2'd0, 64'hAAAA_BBBB_CCCC_DDDD, mask_q);
        sel = result;
        xact(1'b1, 4'h9, 2'd3, mask_q, 64'h1111_2222_3333_4444);
        xact(1'b1, 4'hA, 2'd2, sel, result);
        check("R8", result, 64'hAAAA_2222_3333_4444);

        // Idle cycles hold the result (R1).
        xact(1'b0, 4'h0, 2'd0, 64'hFFFF, 64'hFFFF);
        xact(1'b0, 4'hB, 2'd3, 64'd1, 64'd2);

        // Mixed random traffic with edge-heavy operands.
        for (int n = 0; n < 2500; n++) begin
            logic [1:0] sz = 2'($urandom_range(0, 3));
            logic [3:0] op = 4'($urandom_range(0, 15));
            logic [63:0] a = edge_val($urandom_range(0, 6), sz);
            logic [63:0] b = edge_val($urandom_range(0, 6), sz);
            if (op >= 4'hC && op <= 4'hD && $urandom_range(0, 1) == 0) b = 64'($urandom_range(0, 70));
            xact(($urandom_range(0, 7) != 0), op, sz, a, b);
        end

        summary();
    end

endmodule